// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block drives an external 12-bit converter through an automatic scan of 32 analog inputs. It keeps a five-bit range word for every input. That word sets the gain, picks unipolar or bipolar operation, and can mark an even input as the positive half of a differential pair. The block presents the multiplexer channel and the range of the current input to the analog front end. A single selected trigger source starts each conversion. When the converter reports completion, the block returns the 12-bit value tagged with the channel it came from.

Software sets a first channel and a last channel. After each completed conversion the scan steps to the next input and returns to the first channel after the last one. The scan may wrap through channel 31 to channel 0. An odd input whose even partner is marked differential is skipped. Conversions can be requested by a software strobe, by a periodic pacer tick, or by a rising edge on an asynchronous external pin. The external pin can be qualified by a gate level.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset `conv_start`, `res_valid` and `cfg_err` are low, `mux_ch` is 0 and every range word is zero.
- R2: A range word is 5 bits: bit 4 marks differential, bit 3 selects unipolar, bits 2:0 hold the gain code. A `rng_we` pulse stores `rng_code` for the channel last written as the first channel. `gain_code`, `unipolar` and `mux_diff` always show the range of the channel on `mux_ch`.
- R3: A `rng_we` pulse has no effect while any of the three trigger enables is set.
- R4: A `lim_we` pulse loads the first and last channels and moves the scan to the first channel. After each completed conversion the scan steps up by one (31 wraps to 0). From the last channel it returns to the first. The channel holds still at all other times.
- R5: From an even channel whose range has bit 4 set, the scan steps by two, skipping the odd partner. If the last channel is that partner, the scan returns to the first channel instead. When the scan sits on such a partner, `mux_ch` shows the even channel, together with the even channel's range.
- R6: With only the software enable set, a `sw_trig` pulse sampled on edge k raises `conv_start` for exactly the one cycle after edge k.
- R7: With only the pacer enable set, a `pacer_tick` pulse starts one conversion.
- R8: With only the external enable set, a low-to-high change of `ext_trig` is synchronized by two flops and raises `conv_start` after the third clock edge that samples the new level. While gating is enabled and `ext_gate` is low, external edges start nothing.
- R9: While more than one trigger enable is set, `cfg_err` is high and no conversion starts.
- R10: A trigger that arrives while a conversion is outstanding, or while `conv_busy` is high, is dropped and is not queued.
- R11: The cycle after `conv_done` is sampled high during a conversion, `res_valid` is high for one cycle. In that cycle `res_data` holds `conv_data` and `res_ch` holds the channel that was on `mux_ch` for that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lim_we | input | 1 | Load first/last scan channels |
| lim_first | input | 5 | First scan channel |
| lim_last | input | 5 | Last scan channel |
| rng_we | input | 1 | Store a range word |
| rng_code | input | 5 | Range word {diff, unipolar, gain[2:0]} |
| ctl_we | input | 1 | Load trigger enables |
| ctl_sw_en | input | 1 | Software trigger enable |
| ctl_pacer_en | input | 1 | Pacer trigger enable |
| ctl_ext_en | input | 1 | External trigger enable |
| ctl_gate_en | input | 1 | External gate qualification enable |
| sw_trig | input | 1 | Software trigger strobe |
| pacer_tick | input | 1 | Pacer pulse |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| ext_gate | input | 1 | Asynchronous external gate level |
| conv_busy | input | 1 | Converter busy |
| conv_done | input | 1 | Converter finished strobe |
| conv_data | input | 12 | Converter result |
| conv_start | output | 1 | Start-conversion pulse |
| mux_ch | output | 5 | Multiplexer channel code |
| mux_diff | output | 1 | Differential selection for mux_ch |
| unipolar | output | 1 | Unipolar selection for mux_ch |
| gain_code | output | 3 | Gain code for mux_ch |
| cfg_err | output | 1 | More than one trigger enable set |
| res_valid | output | 1 | Result strobe |
| res_data | output | 12 | Result value |
| res_ch | output | 5 | Channel of the result |

## Verification
The assertions assume that the converter raises `conv_done` only for one cycle, and only after a `conv_start` that the block issued. They also assume that `sw_trig` and `pacer_tick` are single-cycle strobes. The bench converter model raises `conv_done` exactly once per observed start, three cycles later, and holds `conv_busy` in between. Every strobe it drives lasts one cycle. Between negative edges the external pin is held for several cycles, so the synchronizer sees clean levels.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef struct packed {
    logic       diff;
    logic       unipolar;
    logic [2:0] gain;
  } range_t;

  localparam int RANGE_W = $bits(range_t);

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } conv_state_t;

  // True when two or more of the three enables are set.
  function automatic logic multi_enable(input logic [2:0] en);
    return (en[0] & en[1]) | (en[0] & en[2]) | (en[1] & en[2]);
  endfunction

  // Any enable set: range memory is locked.
  function automatic logic any_enable(input logic [2:0] en);
    return |en;
  endfunction

endpackage

// File: rtl/scan_range_store.sv
module scan_range_store #(
  parameter int CH_W = 5,
  parameter int RW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lock,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_ch,
  input  logic [RW-1:0]   wr_code,
  input  logic [CH_W-1:0] rd_a_ch,
  input  logic [CH_W-1:0] rd_b_ch,
  output logic [RW-1:0]   rd_a,
  output logic [RW-1:0]   rd_b
);
  localparam int CH_N = 1 << CH_W;

  logic [RW-1:0]      cell_q [CH_N];
  logic [CH_N*RW-1:0] mem_flat;
  logic               wr_ok;

  assign wr_ok = wr_en & ~lock;

  for (genvar g = 0; g < CH_N; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)
        cell_q[g] <= '0;
      else if (wr_ok && (wr_ch == CH_W'(g)))
        cell_q[g] <= wr_code;
    end
    assign mem_flat[g*RW +: RW] = cell_q[g];
  end

  assign rd_a = cell_q[rd_a_ch];
  assign rd_b = cell_q[rd_b_ch];

  // R3: locked memory never changes on the following edge
  p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(mem_flat));

endmodule

// File: rtl/scan_trig_select.sv
module scan_trig_select (
  input  logic clk,
  input  logic rst_n,
  input  logic en_sw,
  input  logic en_pacer,
  input  logic en_ext,
  input  logic en_gate,
  input  logic sw_trig,
  input  logic pacer_tick,
  input  logic ext_trig,
  input  logic ext_gate,
  output logic cfg_err,
  output logic trig_hit,
  output logic ext_rise
);
  import scan_pkg::*;

  logic [2:0] ext_sh_q;
  logic [1:0] gate_sh_q;
  logic       gate_ok;
  logic       hit_sw, hit_pacer, hit_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_sh_q  <= '0;
      gate_sh_q <= '0;
    end else begin
      ext_sh_q  <= {ext_sh_q[1:0], ext_trig};
      gate_sh_q <= {gate_sh_q[0], ext_gate};
    end
  end

  assign ext_rise  = ext_sh_q[1] & ~ext_sh_q[2];
  assign gate_ok   = ~en_gate | gate_sh_q[1];
  assign cfg_err   = multi_enable({en_ext, en_pacer, en_sw});
  assign hit_sw    = en_sw & sw_trig;
  assign hit_pacer = en_pacer & pacer_tick;
  assign hit_ext   = en_ext & ext_rise & gate_ok;
  assign trig_hit  = ~cfg_err & (hit_sw | hit_pacer | hit_ext);

  // R8: the synchronized edge detector yields a single-cycle pulse
  p_rise_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise);

endmodule

// File: rtl/scan_stepper.sv
module scan_stepper #(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lim_we,
  input  logic [CH_W-1:0] lim_first,
  input  logic [CH_W-1:0] lim_last,
  input  logic            adv,
  input  logic            cur_diff,
  input  logic            pair_diff,
  output logic [CH_W-1:0] cur_ch,
  output logic [CH_W-1:0] pair_ch,
  output logic [CH_W-1:0] eff_ch,
  output logic [CH_W-1:0] first_ch
);
  localparam logic [CH_W-1:0] CH_ONE = CH_W'(1);
  localparam logic [CH_W-1:0] CH_TWO = CH_W'(2);

  logic [CH_W-1:0] cur_q, first_q, last_q;
  logic            two_step;
  logic            on_partner;

  function automatic logic [CH_W-1:0] next_ch(
    input logic [CH_W-1:0] cur,
    input logic [CH_W-1:0] first,
    input logic [CH_W-1:0] last,
    input logic            two
  );
    logic [CH_W-1:0] up1;
    up1 = cur + CH_ONE;
    if (cur == last)
      return first;
    if (two && (up1 == last))
      return first;
    return two ? (cur + CH_TWO) : up1;
  endfunction

  assign pair_ch    = {cur_q[CH_W-1:1], 1'b0};
  assign two_step   = ~cur_q[0] & cur_diff;
  assign on_partner = cur_q[0] & pair_diff;
  assign eff_ch     = on_partner ? pair_ch : cur_q;
  assign cur_ch     = cur_q;
  assign first_ch   = first_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q   <= '0;
      first_q <= '0;
      last_q  <= '0;
    end else if (lim_we) begin
      cur_q   <= lim_first;
      first_q <= lim_first;
      last_q  <= lim_last;
    end else if (adv) begin
      cur_q   <= next_ch(cur_q, first_q, last_q, two_step);
    end
  end

  // R4: the channel moves only on completion or limit load
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !lim_we) |=> $stable(cur_q));

  // R4: from the last channel the scan returns to the first
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !lim_we && cur_q == last_q) |=> (cur_q == first_q));

  // R5: a differential even channel never steps onto its partner
  p_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !lim_we && !cur_q[0] && cur_diff && cur_q != last_q)
      |=> (cur_q != ($past(cur_q) + CH_ONE)));

endmodule

// File: rtl/scan_conv_ctrl.sv
module scan_conv_ctrl #(
  parameter int CH_W   = 5,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_hit,
  input  logic              conv_busy,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic [CH_W-1:0]   tag_ch,
  output logic              conv_start,
  output logic              adv,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic [CH_W-1:0]   res_ch
);
  import scan_pkg::*;

  conv_state_t st_q;
  logic        accept;

  assign accept = (st_q == ST_IDLE) & trig_hit & ~conv_busy;
  assign adv    = (st_q == ST_WAIT) & conv_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      conv_start <= 1'b0;
      res_valid  <= 1'b0;
      res_data   <= '0;
      res_ch     <= '0;
    end else begin
      conv_start <= accept;
      res_valid  <= adv;
      if (adv) begin
        res_data <= conv_data;
        res_ch   <= tag_ch;
      end
      case (st_q)
        ST_IDLE: if (accept) st_q <= ST_WAIT;
        ST_WAIT: if (conv_done) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R6: start is a one-cycle pulse
  p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R10: a start is only issued from the idle state
  p_drop_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(st_q == ST_IDLE && !conv_busy));

  // R11: a result follows a sampled completion and lasts one cycle
  p_res_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(conv_done));
  p_res_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int CH_W   = 5,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lim_we,
  input  logic [CH_W-1:0]   lim_first,
  input  logic [CH_W-1:0]   lim_last,
  input  logic              rng_we,
  input  logic [4:0]        rng_code,
  input  logic              ctl_we,
  input  logic              ctl_sw_en,
  input  logic              ctl_pacer_en,
  input  logic              ctl_ext_en,
  input  logic              ctl_gate_en,
  input  logic              sw_trig,
  input  logic              pacer_tick,
  input  logic              ext_trig,
  input  logic              ext_gate,
  input  logic              conv_busy,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              conv_start,
  output logic [CH_W-1:0]   mux_ch,
  output logic              mux_diff,
  output logic              unipolar,
  output logic [2:0]        gain_code,
  output logic              cfg_err,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic [CH_W-1:0]   res_ch
);
  import scan_pkg::*;

  logic [2:0]      en_q;     // {ext, pacer, sw}
  logic            gate_en_q;
  logic            lock;
  logic            trig_hit, ext_rise, adv;
  logic [CH_W-1:0] cur_ch, pair_ch, eff_ch, first_ch;
  range_t          rng_cur, rng_pair, rng_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= '0;
      gate_en_q <= 1'b0;
    end else if (ctl_we) begin
      en_q      <= {ctl_ext_en, ctl_pacer_en, ctl_sw_en};
      gate_en_q <= ctl_gate_en;
    end
  end

  assign lock = any_enable(en_q);

  scan_range_store #(.CH_W(CH_W), .RW(RANGE_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock    (lock),
    .wr_en   (rng_we),
    .wr_ch   (first_ch),
    .wr_code (rng_code),
    .rd_a_ch (cur_ch),
    .rd_b_ch (pair_ch),
    .rd_a    (rng_cur),
    .rd_b    (rng_pair)
  );

  scan_trig_select u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_sw      (en_q[0]),
    .en_pacer   (en_q[1]),
    .en_ext     (en_q[2]),
    .en_gate    (gate_en_q),
    .sw_trig    (sw_trig),
    .pacer_tick (pacer_tick),
    .ext_trig   (ext_trig),
    .ext_gate   (ext_gate),
    .cfg_err    (cfg_err),
    .trig_hit   (trig_hit),
    .ext_rise   (ext_rise)
  );

  scan_stepper #(.CH_W(CH_W)) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .lim_we    (lim_we),
    .lim_first (lim_first),
    .lim_last  (lim_last),
    .adv       (adv),
    .cur_diff  (rng_cur.diff),
    .pair_diff (rng_pair.diff),
    .cur_ch    (cur_ch),
    .pair_ch   (pair_ch),
    .eff_ch    (eff_ch),
    .first_ch  (first_ch)
  );

  scan_conv_ctrl #(.CH_W(CH_W), .DATA_W(DATA_W)) u_conv (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_hit   (trig_hit),
    .conv_busy  (conv_busy),
    .conv_done  (conv_done),
    .conv_data  (conv_data),
    .tag_ch     (eff_ch),
    .conv_start (conv_start),
    .adv        (adv),
    .res_valid  (res_valid),
    .res_data   (res_data),
    .res_ch     (res_ch)
  );

  assign rng_eff   = (eff_ch == cur_ch) ? rng_cur : rng_pair;
  assign mux_ch    = eff_ch;
  assign mux_diff  = rng_eff.diff;
  assign unipolar  = rng_eff.unipolar;
  assign gain_code = rng_eff.gain;

  // R9: no conversion starts from a conflicting enable set
  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_err) |-> !conv_start);

  // R5: a displayed odd channel is never part of a differential pair
  p_partner_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mux_ch[0] |-> !rng_pair.diff);

endmodule

// File: tb/tb_adc_scan_seq.sv
`timescale 1ns/1ps
module tb_adc_scan_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lim_we = 0, rng_we = 0, ctl_we = 0;
  logic [4:0]  lim_first = 0, lim_last = 0, rng_code = 0;
  logic        ctl_sw_en = 0, ctl_pacer_en = 0, ctl_ext_en = 0, ctl_gate_en = 0;
  logic        sw_trig = 0, pacer_tick = 0, ext_trig = 0, ext_gate = 0;
  logic        conv_busy = 0, conv_done = 0;
  logic [11:0] conv_data = 0;
  logic        conv_start, mux_diff, unipolar, cfg_err, res_valid;
  logic [4:0]  mux_ch, res_ch;
  logic [2:0]  gain_code;
  logic [11:0] res_data;

  int checks = 0, errors = 0, start_cnt = 0, res_cnt = 0;
  int exp_q[$];
  bit tb_diff [32];
  int tb_cur = 0, tb_first = 0, tb_last = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  adc_scan_seq dut (
    .clk(clk), .rst_n(rst_n), .lim_we(lim_we), .lim_first(lim_first),
    .lim_last(lim_last), .rng_we(rng_we), .rng_code(rng_code),
    .ctl_we(ctl_we), .ctl_sw_en(ctl_sw_en), .ctl_pacer_en(ctl_pacer_en),
    .ctl_ext_en(ctl_ext_en), .ctl_gate_en(ctl_gate_en), .sw_trig(sw_trig),
    .pacer_tick(pacer_tick), .ext_trig(ext_trig), .ext_gate(ext_gate),
    .conv_busy(conv_busy), .conv_done(conv_done), .conv_data(conv_data),
    .conv_start(conv_start), .mux_ch(mux_ch), .mux_diff(mux_diff),
    .unipolar(unipolar), .gain_code(gain_code), .cfg_err(cfg_err),
    .res_valid(res_valid), .res_data(res_data), .res_ch(res_ch)
  );

  function automatic logic [11:0] conv_val(input int ch);
    logic [4:0] c5;
    c5 = ch[4:0];
    return {c5, 7'h2B} ^ 12'h5A5;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference scan model
  function automatic int ref_eff();
    if ((tb_cur % 2 == 1) && tb_diff[tb_cur-1]) return tb_cur - 1;
    return tb_cur;
  endfunction

  task automatic ref_step();
    bit two;
    two = (tb_cur % 2 == 0) && tb_diff[tb_cur];
    if (tb_cur == tb_last || (two && ((tb_cur + 1) % 32) == tb_last))
      tb_cur = tb_first;
    else
      tb_cur = (tb_cur + (two ? 2 : 1)) % 32;
  endtask

  // Converter model
  initial begin
    forever begin
      @(negedge clk);
      if (conv_start) begin
        int ch;
        start_cnt++;
        ch = int'(mux_ch);
        conv_busy = 1;
        repeat (3) @(negedge clk);
        conv_done = 1;
        conv_data = conv_val(ch);
        @(negedge clk);
        conv_done = 0;
        conv_busy = 0;
      end
    end
  end

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (res_valid) begin
        int e;
        if (exp_q.size() == 0) begin
          check(0, "R11", "unexpected result ch", int'(res_ch), -1);
        end else begin
          e = exp_q.pop_front();
          check(int'(res_ch) == e, "R4/R5/R11", "result channel", int'(res_ch), e);
          check(res_data == conv_val(e), "R11", "result data",
                int'(res_data), int'(conv_val(e)));
        end
        res_cnt++;
      end
    end
  end

  task automatic write_lim(input int f, input int l);
    @(negedge clk);
    lim_we = 1; lim_first = f[4:0]; lim_last = l[4:0];
    @(negedge clk);
    lim_we = 0;
    tb_first = f; tb_last = l; tb_cur = f;
  endtask

  task automatic write_rng(input logic [4:0] code);
    @(negedge clk);
    rng_we = 1; rng_code = code;
    @(negedge clk);
    rng_we = 0;
  endtask

  task automatic write_ctl(input bit s, input bit p, input bit x, input bit g);
    @(negedge clk);
    ctl_we = 1; ctl_sw_en = s; ctl_pacer_en = p; ctl_ext_en = x; ctl_gate_en = g;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic set_range(input int ch, input logic [4:0] code);
    write_lim(ch, ch);
    write_rng(code);
    tb_diff[ch] = code[4];
  endtask

  task automatic wait_res(input int target, input string req);
    for (int i = 0; i < 40 && res_cnt < target; i++) @(negedge clk);
    check(res_cnt >= target, req, "result count", res_cnt, target);
  endtask

  task automatic sw_conv();
    int tgt;
    tgt = res_cnt + 1;
    exp_q.push_back(ref_eff());
    @(negedge clk); sw_trig = 1;
    @(negedge clk); sw_trig = 0;
    wait_res(tgt, "R6");
    ref_step();
    repeat (2) @(negedge clk);
  endtask

  task automatic ext_pulse();
    @(negedge clk); ext_trig = 1;
    repeat (4) @(negedge clk);
    ext_trig = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check(conv_start == 0, "R1", "conv_start", int'(conv_start), 0);
    check(res_valid == 0, "R1", "res_valid", int'(res_valid), 0);
    check(mux_ch == 0, "R1", "mux_ch", int'(mux_ch), 0);
    check(cfg_err == 0, "R1", "cfg_err", int'(cfg_err), 0);
    check(gain_code == 0 && unipolar == 0 && mux_diff == 0, "R1", "range 0",
          int'(gain_code), 0);

    // R2: range words
    set_range(3, 5'b01011);
    set_range(4, 5'b10001);
    set_range(6, 5'b10010);
    set_range(30, 5'b01001);
    write_lim(3, 3);
    @(negedge clk);
    check(mux_ch == 3, "R2", "mux_ch", int'(mux_ch), 3);
    check(gain_code == 3, "R2", "gain", int'(gain_code), 3);
    check(unipolar == 1 && mux_diff == 0, "R2", "unipolar", int'(unipolar), 1);

    // R5: partner shows the even channel and its range
    write_lim(7, 7);
    @(negedge clk);
    check(mux_ch == 6, "R5", "partner mux_ch", int'(mux_ch), 6);
    check(gain_code == 2 && mux_diff == 1, "R5", "partner gain", int'(gain_code), 2);

    // R6: software trigger latency, one cycle
    write_ctl(1, 0, 0, 0);
    write_lim(2, 8);
    begin
      int tgt;
      tgt = res_cnt + 1;
      exp_q.push_back(ref_eff());
      @(negedge clk); sw_trig = 1;
      @(negedge clk); sw_trig = 0;
      check(conv_start == 1, "R6", "start after edge", int'(conv_start), 1);
      @(negedge clk);
      check(conv_start == 0, "R6", "start width", int'(conv_start), 0);
      wait_res(tgt, "R6");
      ref_step();
      repeat (2) @(negedge clk);
    end
    // R4/R5: scan 2..8 with two differential pairs
    for (int i = 0; i < 6; i++) sw_conv();

    // R4: wrap through 31 to 0
    write_lim(30, 1);
    for (int i = 0; i < 5; i++) sw_conv();

    // R5: last channel is a skipped partner
    write_lim(4, 5);
    for (int i = 0; i < 3; i++) sw_conv();
    check(mux_ch == 4, "R5", "returns to first", int'(mux_ch), 4);

    // R10: second trigger while busy is dropped
    begin
      int s0, tgt;
      s0 = start_cnt; tgt = res_cnt + 1;
      exp_q.push_back(ref_eff());
      @(negedge clk); sw_trig = 1;
      @(negedge clk); sw_trig = 0;
      @(negedge clk); sw_trig = 1;
      @(negedge clk); sw_trig = 0;
      wait_res(tgt, "R10");
      ref_step();
      repeat (4) @(negedge clk);
      check(start_cnt == s0 + 1, "R10", "starts", start_cnt, s0 + 1);
    end

    // R3: range write while an enable is set has no effect
    write_lim(3, 3);
    write_rng(5'b00111);
    write_ctl(0, 0, 0, 0);
    @(negedge clk);
    check(gain_code == 3 && unipolar == 1, "R3", "locked gain", int'(gain_code), 3);

    // R7: pacer
    write_ctl(0, 1, 0, 0);
    write_lim(2, 8);
    begin
      int tgt;
      tgt = res_cnt + 1;
      exp_q.push_back(ref_eff());
      @(negedge clk); pacer_tick = 1;
      @(negedge clk); pacer_tick = 0;
      wait_res(tgt, "R7");
      ref_step();
      repeat (2) @(negedge clk);
    end

    // R8: external edge latency
    write_ctl(0, 0, 1, 0);
    begin
      int tgt;
      tgt = res_cnt + 1;
      exp_q.push_back(ref_eff());
      @(negedge clk); ext_trig = 1;
      @(negedge clk);
      check(conv_start == 0, "R8", "no start at edge 1", int'(conv_start), 0);
      @(negedge clk);
      check(conv_start == 0, "R8", "no start at edge 2", int'(conv_start), 0);
      @(negedge clk);
      check(conv_start == 1, "R8", "start at edge 3", int'(conv_start), 1);
      repeat (2) @(negedge clk);
      ext_trig = 0;
      wait_res(tgt, "R8");
      ref_step();
      repeat (4) @(negedge clk);
    end

    // R8: gate low blocks, gate high passes
    write_ctl(0, 0, 1, 1);
    ext_gate = 0;
    begin
      int s0, tgt;
      s0 = start_cnt;
      ext_pulse();
      repeat (6) @(negedge clk);
      check(start_cnt == s0, "R8", "gated off", start_cnt, s0);
      ext_gate = 1;
      repeat (4) @(negedge clk);
      tgt = res_cnt + 1;
      exp_q.push_back(ref_eff());
      ext_pulse();
      wait_res(tgt, "R8");
      ref_step();
      repeat (4) @(negedge clk);
    end

    // R9: conflicting enables
    write_ctl(1, 1, 0, 0);
    @(negedge clk);
    check(cfg_err == 1, "R9", "cfg_err", int'(cfg_err), 1);
    begin
      int s0;
      s0 = start_cnt;
      @(negedge clk); sw_trig = 1; pacer_tick = 1;
      @(negedge clk); sw_trig = 0; pacer_tick = 0;
      repeat (6) @(negedge clk);
      check(start_cnt == s0, "R9", "no start", start_cnt, s0);
    end
    write_ctl(0, 0, 0, 0);
    @(negedge clk);
    check(cfg_err == 0, "R9", "cfg_err cleared", int'(cfg_err), 0);
    check(exp_q.size() == 0, "R11", "pending results", exp_q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule